// File: doc/BRIEF.md
# Character Strip Pixel Generator

This block turns one scan line of a text strip into colour and fast-blank pixels for an on-screen overlay. Once a horizontal sync falling edge arrives, it counts pixel clocks, waits a programmable left margin and then lays out 12-pixel character cells. For each cell it reads a 16-bit code word from the display RAM, decodes it and fetches two font rows. The first row belongs to the current slice and the second to the slice above it. A font row comes either from the external character ROM or from a user-defined glyph held in the same RAM.

Each code word carries a font-source flag, a 7-bit character number, a background/shadow field, a flash flag and a 3-bit foreground colour. The block applies these per pixel, together with global controls: overlay enable, fast-blank-outside enable and a two-bit flash duty mode. A frame counter stepped by vertical sync falling edges supplies the time base for flashing. The surrounding system supplies the slice number, the address of the strip's first code, and the register values for line length and margin.

Top module: `osd_pixel_gen`

## Requirements
- R1: While `osdEn` is 0, `pixRgb` and `pixFblk` are 0 one clock later, whatever the other inputs are. Both outputs are also 0 after reset.
- R2: Pixel p counts clocks from the first cycle after a sampled `hsync` falling edge, starting at p = 0. Character k covers pixels S+12k to S+12k+11, where S = (`hDelay`+8)×3 and `hDelay` ≥ 4. No character pixel appears before S.
- R3: The line length is L = (`lineDur`+1)×12. No character pixel is produced at p ≥ L, and any cell that crosses L is cut off at L.
- R4: A code word is laid out as bit 15 = source flag, [14:8] = character number, [7:4] = background field, [3] = flash flag and [2:0] = foreground {R,G,B}. When bit 15 is 0, the font row is read from `romRow` at `romAddr` = {number, slice}. Row bit 11 is the leftmost pixel, and a 1 shows the foreground colour with `pixFblk` = 1.
- R5: When bit 15 is 1 and the number is 0..25, the row comes from RAM word 19×number + slice. Word bits [7:0] hold pixels 7..0 and bits [11:8] hold pixels 11..8. Bits [15:12] are ignored.
- R6: When bit 15 is 1 and the number is 26..63, the cell has no foreground pixels and shows only its background.
- R7: When bit 15 is 1 and the number is above 63, the line ends. That cell and every later cell of the line are shown as outside area.
- R8: When background bit 7 is 0, non-foreground pixels of the cell show bits [6:4] as the colour, with `pixFblk` = 1.
- R9: When background bit 7 is 1, a non-foreground pixel is black with `pixFblk` = 1 in either of two cases. Vertical shadow is on (bit 6) and the same column of the slice above is foreground. Horizontal shadow is on (bit 5) and the previous pixel on the line was foreground, even if that pixel was in the previous cell. Slice 0 has no row above. Any other pixel is transparent.
- R10: The frame counter f (0..31) steps on each `vsync` falling edge. A flagged character's foreground pixels, including their shadow effect, are hidden in these cases: mode 01 when f ≥ 16, mode 10 when f ≥ 8, mode 11 when f ≥ 24. Mode 00 ignores the flag.
- R11: Outside character cells, and on transparent pixels, `pixRgb` = 0 and `pixFblk` = `fbEn`.
- R12: The output for pixel p is registered. It appears one clock after the cycle in which the pixel counter holds p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync; the falling edge starts a line |
| vsync | input | 1 | Vertical sync; the falling edge steps the flash frame counter |
| lineDur | input | 6 | Line length in cells minus one |
| hDelay | input | 8 | Left margin code, in units of 3 pixels with an offset of 8 |
| osdEn | input | 1 | Overlay enable |
| fbEn | input | 1 | Fast blank held high outside characters |
| flashMode | input | 2 | Flash duty mode |
| sliceNum | input | 5 | Font slice for this scan line (0..17) |
| codeStart | input | 10 | RAM word address of the strip's first code |
| ramAddr | output | 10 | RAM word address, code or glyph row |
| ramData | input | 16 | RAM word read at `ramAddr` in the same cycle |
| romAddr | output | 12 | ROM row address {number, slice} |
| romRow | input | 12 | ROM row read at `romAddr` in the same cycle |
| pixRgb | output | 3 | Pixel colour {R,G,B} |
| pixFblk | output | 1 | Fast-blank pixel output |

## Verification
Two things can land on the same pixel clock: the first pixel of a new cell, which is the cycle right after the shift row is reloaded, and a horizontal shadow caused by the last foreground pixel of the previous cell. The UDC strip sets this up with a glyph whose rightmost column is lit, followed by a cell with horizontal shadowing. Vertical shadow and flash hiding also meet on the same pixel when a flagged, shadowed character runs in a hidden flash phase. In every such case a scoreboard compares the pixel stream with a per-pixel model built from the code words, the glyph memory contents and the frame count.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int CELL_PX    = 12;
  localparam int UDC_COUNT  = 26;
  localparam int UDC_STRIDE = 19;
  localparam int SPACE_LAST = 63;

  typedef struct packed {
    logic lineStart;
    logic fetchCode;
    logic fetchRow;
    logic fetchAbove;
    logic loadCell;
    logic inLine;
  } osd_strobe_t;
endpackage

// File: rtl/osd_timing_ctrl.sv
module osd_timing_ctrl
  import osd_pkg::*;
#(
  parameter int LD_W  = 6,
  parameter int DLY_W = 8,
  parameter int PIX_W = 11,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic [LD_W-1:0]  lineDur,
  input  logic [DLY_W-1:0] hDelay,
  output osd_strobe_t      st,
  output logic [IDX_W-1:0] codeIdx
);
  localparam int PH_W = $clog2(CELL_PX);

  logic             hsPrev, lineOn, runReg;
  logic [PIX_W-1:0] pix, lineLen, firstFetch;
  logic [PH_W-1:0]  phaseReg, ph;
  logic [IDX_W-1:0] idxReg, idx;
  logic             hsFall, inLine, winStart, active, lastPh;

  assign hsFall     = hsPrev && !hsync;
  assign lineLen    = (PIX_W'(lineDur) + PIX_W'(1)) * PIX_W'(CELL_PX);
  assign firstFetch = (PIX_W'(hDelay) + PIX_W'(8)) * PIX_W'(3) - PIX_W'(CELL_PX);
  assign inLine     = lineOn && (pix < lineLen);
  assign winStart   = inLine && !runReg && (pix == firstFetch);
  assign active     = inLine && (runReg || winStart) && !hsFall;
  assign ph         = winStart ? '0 : phaseReg;
  assign idx        = winStart ? '0 : idxReg;
  assign lastPh     = (ph == PH_W'(CELL_PX - 1));

  always_comb begin
    st.lineStart  = hsFall;
    st.fetchCode  = active && (ph == PH_W'(0));
    st.fetchRow   = active && (ph == PH_W'(1));
    st.fetchAbove = active && (ph == PH_W'(2));
    st.loadCell   = active && lastPh;
    st.inLine     = inLine;
    codeIdx       = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsPrev   <= 1'b0;
      lineOn   <= 1'b0;
      pix      <= '0;
      runReg   <= 1'b0;
      phaseReg <= '0;
      idxReg   <= '0;
    end else begin
      hsPrev <= hsync;
      if (hsFall) begin
        lineOn   <= 1'b1;
        pix      <= '0;
        runReg   <= 1'b0;
        phaseReg <= '0;
        idxReg   <= '0;
      end else begin
        if (inLine) pix <= pix + PIX_W'(1);
        if (active) begin
          runReg   <= 1'b1;
          phaseReg <= lastPh ? '0 : ph + PH_W'(1);
          idxReg   <= lastPh ? idx + IDX_W'(1) : idx;
        end
      end
    end
  end

  // R2: the fetch and load phases of a cell never overlap
  assert_fetch_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st.fetchCode, st.fetchRow, st.fetchAbove, st.loadCell}));

  // R4: a font row is only ever read right after its code word
  assert_row_after_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st.fetchRow |-> $past(st.fetchCode));

  // R3: no fetch is issued once the line length is used up
  assert_fetch_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st.fetchAbove |-> $past(st.inLine));
endmodule

// File: rtl/osd_pixel_path.sv
module osd_pixel_path
  import osd_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int RAM_AW  = 10,
  parameter int SL_W    = 5,
  parameter int FLASH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  osd_strobe_t       st,
  input  logic [IDX_W-1:0]  codeIdx,
  input  logic              vsync,
  input  logic              osdEn,
  input  logic              fbEn,
  input  logic [1:0]        flashMode,
  input  logic [SL_W-1:0]   sliceNum,
  input  logic [RAM_AW-1:0] codeStart,
  output logic [RAM_AW-1:0] ramAddr,
  input  logic [15:0]       ramData,
  output logic [11:0]       romAddr,
  input  logic [11:0]       romRow,
  output logic [2:0]        pixRgb,
  output logic              pixFblk
);
  logic [15:0]        pendCode;
  logic [11:0]        pendRow, pendAbove, curRow, curAbove, rowData;
  logic [7:0]         curAttr;
  logic               pendValid, curValid, eolSeen, prevFg;
  logic               vsPrev;
  logic [FLASH_W-1:0] frameCnt;
  logic [SL_W-1:0]    rowSlice;
  logic [RAM_AW-1:0]  udcBase;
  logic [6:0]         pNum;
  logic               pSet, isEol, flashHide, hide, showChar, fgBit, abvBit, fgNow, fbN;
  logic [2:0]         rgbN;
  logic [1:0]         fTop;

  assign pSet     = pendCode[15];
  assign pNum     = pendCode[14:8];
  assign isEol    = ramData[15] && (ramData[14:8] > 7'(SPACE_LAST));
  assign rowSlice = st.fetchAbove ? sliceNum - SL_W'(1) : sliceNum;
  assign udcBase  = RAM_AW'(pNum) * RAM_AW'(UDC_STRIDE);
  assign romAddr  = {pNum, rowSlice};

  always_comb begin
    if (st.fetchRow || st.fetchAbove) ramAddr = udcBase + RAM_AW'(rowSlice);
    else                              ramAddr = codeStart + RAM_AW'(codeIdx);
  end

  always_comb begin
    if (!pSet)                          rowData = romRow;
    else if (pNum < 7'(UDC_COUNT))      rowData = ramData[11:0];
    else                                rowData = '0;
  end

  // flash time base from vertical sync
  assign fTop = frameCnt[FLASH_W-1 -: 2];
  always_comb begin
    case (flashMode)
      2'b01:   flashHide = fTop[1];
      2'b10:   flashHide = (fTop != 2'b00);
      2'b11:   flashHide = (fTop == 2'b11);
      default: flashHide = 1'b0;
    endcase
  end

  assign showChar = st.inLine && curValid;
  assign hide     = curAttr[3] && flashHide;
  assign fgBit    = curRow[11] && !hide;
  assign abvBit   = curAbove[11] && !hide;

  always_comb begin
    rgbN  = '0;
    fbN   = fbEn;
    fgNow = 1'b0;
    if (showChar) begin
      if (fgBit) begin
        rgbN  = curAttr[2:0];
        fbN   = 1'b1;
        fgNow = 1'b1;
      end else if (!curAttr[7]) begin
        rgbN = curAttr[6:4];
        fbN  = 1'b1;
      end else if ((curAttr[6] && abvBit) || (curAttr[5] && prevFg)) begin
        fbN = 1'b1;
      end
    end
    if (!osdEn) begin
      rgbN = '0;
      fbN  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsPrev   <= 1'b0;
      frameCnt <= '0;
    end else begin
      vsPrev <= vsync;
      if (vsPrev && !vsync) frameCnt <= frameCnt + FLASH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCode  <= '0;
      pendRow   <= '0;
      pendAbove <= '0;
      pendValid <= 1'b0;
      eolSeen   <= 1'b0;
      curRow    <= '0;
      curAbove  <= '0;
      curAttr   <= '0;
      curValid  <= 1'b0;
      prevFg    <= 1'b0;
      pixRgb    <= '0;
      pixFblk   <= 1'b0;
    end else begin
      pixRgb  <= rgbN;
      pixFblk <= fbN;
      prevFg  <= fgNow;
      if (st.lineStart) begin
        eolSeen   <= 1'b0;
        pendValid <= 1'b0;
        curValid  <= 1'b0;
      end else begin
        if (st.fetchCode) begin
          pendCode  <= ramData;
          pendValid <= !(eolSeen || isEol);
          eolSeen   <= eolSeen || isEol;
        end
        if (st.fetchRow)   pendRow   <= rowData;
        if (st.fetchAbove) pendAbove <= (sliceNum == '0) ? '0 : rowData;
        if (st.loadCell) begin
          curRow   <= pendRow;
          curAbove <= pendAbove;
          curAttr  <= pendCode[7:0];
          curValid <= pendValid;
        end else begin
          curRow   <= {curRow[10:0], 1'b0};
          curAbove <= {curAbove[10:0], 1'b0};
        end
      end
    end
  end

  // R1: a disabled overlay drives nothing on the next pixel
  assert_osd_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !osdEn |=> (pixRgb == 3'b000 && !pixFblk));

  // R7: once the line has ended it stays ended until the next line
  assert_eol_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eolSeen && !st.lineStart) |=> eolSeen);

  // R3: outside the line there is never a coloured pixel
  assert_no_pixel_past_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !st.inLine |=> (pixRgb == 3'b000));
endmodule

// File: rtl/osd_pixel_gen.sv
module osd_pixel_gen
  import osd_pkg::*;
#(
  parameter int LD_W    = 6,
  parameter int DLY_W   = 8,
  parameter int RAM_AW  = 10,
  parameter int SL_W    = 5,
  parameter int FLASH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [LD_W-1:0]   lineDur,
  input  logic [DLY_W-1:0]  hDelay,
  input  logic              osdEn,
  input  logic              fbEn,
  input  logic [1:0]        flashMode,
  input  logic [SL_W-1:0]   sliceNum,
  input  logic [RAM_AW-1:0] codeStart,
  output logic [RAM_AW-1:0] ramAddr,
  input  logic [15:0]       ramData,
  output logic [11:0]       romAddr,
  input  logic [11:0]       romRow,
  output logic [2:0]        pixRgb,
  output logic              pixFblk
);
  localparam int IDX_W = LD_W + 1;
  localparam int PIX_W = DLY_W + 3;

  osd_strobe_t      st;
  logic [IDX_W-1:0] codeIdx;

  osd_timing_ctrl #(.LD_W(LD_W), .DLY_W(DLY_W), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .lineDur(lineDur), .hDelay(hDelay),
    .st(st), .codeIdx(codeIdx)
  );

  osd_pixel_path #(.IDX_W(IDX_W), .RAM_AW(RAM_AW), .SL_W(SL_W), .FLASH_W(FLASH_W)) u_path (
    .clk(clk), .rst_n(rst_n), .st(st), .codeIdx(codeIdx), .vsync(vsync),
    .osdEn(osdEn), .fbEn(fbEn), .flashMode(flashMode), .sliceNum(sliceNum),
    .codeStart(codeStart), .ramAddr(ramAddr), .ramData(ramData),
    .romAddr(romAddr), .romRow(romRow), .pixRgb(pixRgb), .pixFblk(pixFblk)
  );
endmodule

// File: tb/osd_pixel_gen_bench.sv
module osd_pixel_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b1, vsync = 1'b0;
  logic [5:0] lineDur = 6'd10;
  logic [7:0] hDelay = 8'd4;
  logic osdEn = 1'b0, fbEn = 1'b0;
  logic [1:0] flashMode = 2'b00;
  logic [4:0] sliceNum = 5'd0;
  logic [9:0] codeStart = 10'd0;
  logic [9:0] ramAddr;
  logic [15:0] ramData;
  logic [11:0] romAddr, romRow;
  logic [2:0] pixRgb;
  logic pixFblk;

  logic [15:0] ram [1024];
  int errors = 0, checks = 0, frameNo = 0;
  string curTag;
  logic [3:0] expQ[$];
  event lineGo;

  always #4 clk = ~clk;

  function automatic logic [11:0] romFn(logic [11:0] a);
    return 12'((a * 37) ^ (a >> 3) ^ 12'h5A3);
  endfunction

  assign ramData = ram[ramAddr];
  assign romRow  = romFn(romAddr);

  osd_pixel_gen u_osd_pixel_gen (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .lineDur(lineDur),
    .hDelay(hDelay), .osdEn(osdEn), .fbEn(fbEn), .flashMode(flashMode),
    .sliceNum(sliceNum), .codeStart(codeStart), .ramAddr(ramAddr), .ramData(ramData),
    .romAddr(romAddr), .romRow(romRow), .pixRgb(pixRgb), .pixFblk(pixFblk)
  );

  function automatic logic [11:0] glyph(logic [15:0] code, int slice);
    int num = int'(code[14:8]);
    if (!code[15]) return romFn({code[14:8], 5'(slice)});
    if (num < 26) return ram[num * 19 + slice][11:0];
    return 12'h000;
  endfunction

  function automatic logic hiddenNow();
    case (flashMode)
      2'b01: return frameNo >= 16;
      2'b10: return frameNo >= 8;
      2'b11: return frameNo >= 24;
      default: return 1'b0;
    endcase
  endfunction

  // expected pixel stream built from the requirements
  task automatic buildLine();
    int start = (int'(hDelay) + 8) * 3;
    int len = (int'(lineDur) + 1) * 12;
    logic prev = 1'b0;
    for (int p = 0; p < len + 4; p++) begin
      logic [2:0] rgb = 3'b000;
      logic fb = fbEn;
      logic fgNow = 1'b0;
      if (p < len && p >= start) begin
        int k = (p - start) / 12;
        int j = (p - start) % 12;
        logic eol = 1'b0;
        for (int i = 0; i <= k; i++) begin
          logic [15:0] c = ram[(int'(codeStart) + i) % 1024];
          if (c[15] && c[14:8] > 7'd63) eol = 1'b1;
        end
        if (!eol) begin
          logic [15:0] code = ram[(int'(codeStart) + k) % 1024];
          logic [11:0] row = glyph(code, int'(sliceNum));
          logic [11:0] abv = (sliceNum == 0) ? 12'h000 : glyph(code, int'(sliceNum) - 1);
          logic hide = code[3] && hiddenNow();
          logic b = row[11 - j] && !hide;
          logic a = abv[11 - j] && !hide;
          if (b) begin rgb = code[2:0]; fb = 1'b1; fgNow = 1'b1; end
          else if (!code[7]) begin rgb = code[6:4]; fb = 1'b1; end
          else if ((code[6] && a) || (code[5] && prev)) fb = 1'b1;
        end
      end
      prev = fgNow;
      if (!osdEn) begin rgb = 3'b000; fb = 1'b0; end
      expQ.push_back({rgb, fb});
    end
  endtask

  task automatic runLine(string tag);
    curTag = tag;
    buildLine();
    @(negedge clk);
    hsync = 1'b0;
    -> lineGo;
    wait (expQ.size() == 0);
    @(negedge clk);
    hsync = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: pixel p is sampled at the second negedge after hsync drops (R12)
  initial begin
    forever begin
      @(lineGo);
      @(negedge clk);
      for (int p = 0; expQ.size() > 0; p++) begin
        logic [3:0] e;
        @(negedge clk);
        e = expQ.pop_front();
        checks++;
        if ({pixRgb, pixFblk} !== e) begin
          errors++;
          $display("FAIL %s R12 pixel %0d: actual rgb=%b fblk=%b expected rgb=%b fblk=%b",
                   curTag, p, pixRgb, pixFblk, e[3:1], e[0]);
        end
      end
    end
  end

  task automatic pulseVsync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    frameNo = (frameNo + 1) % 32;
  endtask

  function automatic void putCode(int k, bit s, int num, logic [3:0] bk, bit fl, logic [2:0] rgb);
    ram[(int'(codeStart) + k) % 1024] = {s, 7'(num), bk, fl, rgb};
  endfunction

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 1024; a++) ram[a] = 16'h0000;
    for (int n = 0; n < 26; n++)
      for (int s = 0; s < 19; s++)
        ram[n * 19 + s] = {4'hA, 12'((n * 131 + s * 29) ^ (s << 6) ^ 12'h801)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;   // reset state, R1
    if (pixRgb !== 3'b000 || pixFblk !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual rgb=%b fblk=%b expected rgb=000 fblk=0", pixRgb, pixFblk);
    end

    // R1: overlay disabled over a busy strip
    codeStart = 10'd600; sliceNum = 5'd4; fbEn = 1'b1;
    for (int k = 0; k < 8; k++) putCode(k, 0, 10 + k, 4'b0011, 0, 3'b101);
    osdEn = 1'b0;
    runLine("R1 off");

    // R2 R4 R8 R11: ROM characters with colour and transparent backgrounds
    osdEn = 1'b1; fbEn = 1'b0; hDelay = 8'd4; lineDur = 6'd10;
    codeStart = 10'd700; sliceNum = 5'd5;
    putCode(0, 0, 65, 4'b0011, 0, 3'b100);
    putCode(1, 0, 3, 4'b0110, 0, 3'b001);
    putCode(2, 0, 127, 4'b1000, 0, 3'b010);
    putCode(3, 1, 127, 4'b0000, 0, 3'b000);
    runLine("R2 R4 R8 R11 rom");
    hDelay = 8'd20; lineDur = 6'd20; fbEn = 1'b1;
    runLine("R2 R11 margin");

    // R5 R6 R9: user glyphs, spaces, both shadow kinds and a cell-boundary shadow
    codeStart = 10'd800; sliceNum = 5'd7; hDelay = 8'd6; lineDur = 6'd10; fbEn = 1'b1;
    ram[2 * 19 + 7] = 16'hF801;
    putCode(0, 1, 2, 4'b1110, 0, 3'b111);
    putCode(1, 1, 25, 4'b1010, 0, 3'b110);
    putCode(2, 1, 40, 4'b0101, 0, 3'b011);
    putCode(3, 1, 63, 4'b1000, 0, 3'b001);
    putCode(4, 1, 0, 4'b1100, 0, 3'b101);
    putCode(5, 1, 64, 4'b0000, 0, 3'b000);
    runLine("R5 R6 R9 udc");
    sliceNum = 5'd0;
    runLine("R9 slice0");
    sliceNum = 5'd17;
    runLine("R5 R9 slice17");

    // R7: end of line in the middle of later valid codes
    codeStart = 10'd900; sliceNum = 5'd2; hDelay = 8'd9; lineDur = 6'd20;
    putCode(0, 0, 33, 4'b0001, 0, 3'b110);
    putCode(1, 1, 100, 4'b0111, 0, 3'b111);
    putCode(2, 0, 34, 4'b0111, 0, 3'b010);
    putCode(3, 0, 35, 4'b0010, 0, 3'b011);
    runLine("R7 eol");

    // R3: line shorter than the strip
    codeStart = 10'd520; hDelay = 8'd4; lineDur = 6'd4; fbEn = 1'b0;
    for (int k = 0; k < 10; k++) putCode(k, 0, 40 + k, 4'b0101, 0, 3'b010);
    runLine("R3 short");
    hDelay = 8'd5;
    runLine("R3 cut cell");

    // R10: flash duty modes across the frame counter
    codeStart = 10'd950; lineDur = 6'd12; hDelay = 8'd4; sliceNum = 5'd9; fbEn = 1'b1;
    putCode(0, 0, 70, 4'b0010, 1, 3'b111);
    putCode(1, 0, 71, 4'b0010, 0, 3'b100);
    putCode(2, 0, 72, 4'b1110, 1, 3'b011);
    putCode(3, 0, 73, 4'b1100, 1, 3'b001);
    putCode(4, 1, 120, 4'b0000, 0, 3'b000);
    begin
      int fr[4] = '{5, 12, 20, 28};
      for (int i = 0; i < 4; i++) begin
        while (frameNo != fr[i]) pulseVsync();
        for (int m = 0; m < 4; m++) begin
          flashMode = 2'(m);
          runLine("R10 flash");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule